// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block holds the byte count for a SCSI controller's DMA engine. Host software writes the count one byte at a time into a shadow register. Those writes do not affect a transfer already in progress. When a command with its DMA bit set is issued, the shadow value is copied into the live counter. When a transfer command starts, the block works out how many bytes will actually move. That length is the smaller of the live count and the magnitude of the remaining bus-phase length. In command phase, the remaining length is replaced by a cap of 32 bytes. A live count of zero stands for the full 65536-byte range.

The effective length is loaded into a remaining-length register. That register drops by one on each byte-moved strobe. When it reaches zero, the block does all of the following together:
- pulses `done` for one cycle;
- sets the terminal-count status;
- flags a bus-service interrupt cause;
- clears the live count;
- raises the interrupt.

An interrupt acknowledge clears the interrupt and the cause but leaves terminal count set. Writing a count byte clears terminal count.

A three-state machine sequences the transfer:
- **IDLE** goes to **RUN** on a start with a non-zero length, or straight to **DONE** on a start with a zero length.
- **RUN** goes to **DONE** when the last byte moves. A new start in RUN reloads the length.
- **DONE** lasts one cycle and returns to **IDLE**, unless a new start arrives in that cycle.

Top module: `dmactr_top`

## Requirements
- R1: After reset the live count, remaining length, `tc`, `done`, `irq` and `svc` are all zero.
- R2: A count-byte write (`cnt_sel` 0 = bits 7:0, 1 = bits 15:8) updates only the shadow and leaves `live_count` unchanged. The write clears `tc` on the next edge.
- R3: A `dma_cmd` strobe copies the shadow count into `live_count`.
- R4: Outside command phase, the effective length is min(count, |`phase_len`|), where a live count of 0 counts as 65536.
- R5: In command phase, the effective length is min(count, 32), and `phase_len` is ignored.
- R6: A `xfer_start` strobe loads `remain` with the effective length and clears `tc`.
- R7: In state RUN, each `byte_stb` lowers `remain` by exactly one. With no strobe, `remain` holds its value.
- R8: When the last byte moves, the following all take effect on the next edge:
  - `done` goes high for exactly one cycle;
  - `tc`, `irq` and `svc` are set;
  - `live_count` becomes 0.
- R9: A `byte_stb` while `remain` is zero is ignored: `remain` stays 0 and no `done` pulse appears.
- R10: `int_ack` clears `irq` and `svc` and leaves `tc` unchanged.
- R11: A start whose effective length is zero completes at once: `done` is high in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr | input | 1 | Count-byte write strobe |
| cnt_sel | input | 1 | Byte select for the write (0 low, 1 high) |
| cnt_wdata | input | 8 | Written byte |
| dma_cmd | input | 1 | DMA-mode command strobe: reload live count |
| xfer_start | input | 1 | Transfer-start strobe |
| cmd_phase | input | 1 | Transfer runs in command phase |
| phase_len | input | 18 | Signed remaining bus-phase length |
| byte_stb | input | 1 | One byte moved |
| int_ack | input | 1 | Interrupt acknowledge |
| live_count | output | 16 | Live transfer counter |
| remain | output | 17 | Remaining DMA length |
| done | output | 1 | One-cycle completion pulse |
| tc | output | 1 | Terminal-count status |
| svc | output | 1 | Bus-service interrupt cause |
| irq | output | 1 | Interrupt request |

## Verification
The length computation is tried with the following patterns:
- counts both above and below a positive phase length, which shows the minimum is taken;
- a negative phase length, which shows the magnitude is used;
- a zero count against a large phase length, which shows the 65536 substitution;
- command phase with both a zero and a small count, which shows the 32-byte cap replaces the phase length;
- a zero phase length, which shows the immediate-completion path.

A directed run then steps bytes one at a time, including an idle gap, to separate counting from holding. It strobes after completion to show the strobe is ignored. Finally, acknowledge, write and reload are applied in turn to show which status each one touches.

// File: rtl/dmactr_pkg.sv
package dmactr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/dmactr_shadow.sv
module dmactr_shadow #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [SEL_W-1:0] cnt_sel,
    input  logic [7:0]       cnt_wdata,
    input  logic             dma_cmd,
    input  logic             complete,
    output logic [CNT_W-1:0] shadow,
    output logic [CNT_W-1:0] live
);
    localparam int NBYTES = CNT_W / 8;

    // Each byte lane of the shadow is written on its own.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow[b*8 +: 8] <= 8'h00;
            else if (cnt_wr && cnt_sel == SEL_W'(b))
                shadow[b*8 +: 8] <= cnt_wdata;
        end
    end

    // Completion takes priority over a reload in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live <= '0;
        else if (complete)
            live <= '0;
        else if (dma_cmd)
            live <= shadow;
    end
endmodule

// File: rtl/dmactr_len.sv
module dmactr_len #(
    parameter int CNT_W   = 16,
    parameter int PLEN_W  = 18,
    parameter int CMD_CAP = 32
) (
    input  logic [CNT_W-1:0]  live,
    input  logic              cmd_phase,
    input  logic [PLEN_W-1:0] phase_len,
    output logic [CNT_W:0]    eff_len
);
    localparam int REM_W = CNT_W + 1;
    localparam int CW    = (REM_W > PLEN_W) ? REM_W : PLEN_W;

    logic [REM_W-1:0]  cnt_full;
    logic [PLEN_W-1:0] plen_mag;
    logic [CW-1:0]     limit;
    logic [CW-1:0]     cnt_ext;

    always_comb begin
        // A zero count stands for the full range.
        cnt_full = (live == '0) ? REM_W'(1) << CNT_W : {1'b0, live};
        // Two's-complement negation gives the magnitude, even for the most negative value.
        plen_mag = phase_len[PLEN_W-1] ? (~phase_len + 1'b1) : phase_len;
        limit    = cmd_phase ? CW'(CMD_CAP) : CW'(plen_mag);
        cnt_ext  = CW'(cnt_full);
        eff_len  = (cnt_ext < limit) ? cnt_full : REM_W'(limit);
    end
endmodule

// File: rtl/dmactr_fsm.sv
module dmactr_fsm
    import dmactr_pkg::*;
#(
    parameter int REM_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             byte_stb,
    input  logic [REM_W-1:0] eff_len,
    output logic [REM_W-1:0] remain,
    output xfer_state_t      state,
    output logic             complete,
    output logic             done
);
    xfer_state_t nstate;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (xfer_start)
                    nstate = (eff_len == '0) ? ST_DONE : ST_RUN;
            end
            ST_RUN: begin
                if (xfer_start)
                    nstate = (eff_len == '0) ? ST_DONE : ST_RUN;
                else if (byte_stb && remain == REM_W'(1))
                    nstate = ST_DONE;
            end
            ST_DONE: begin
                if (xfer_start)
                    nstate = (eff_len == '0) ? ST_DONE : ST_RUN;
                else
                    nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    // Remaining-length register: a start loads it, and a byte in RUN lowers it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (xfer_start)
            remain <= eff_len;
        else if (state == ST_RUN && byte_stb && remain != '0)
            remain <= remain - 1'b1;
    end

    // Outputs decoded from the state.
    always_comb begin
        complete = (nstate == ST_DONE) && (state != ST_DONE || xfer_start);
        done     = (state == ST_DONE);
    end
endmodule

// File: rtl/dmactr_top.sv
module dmactr_top
    import dmactr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PLEN_W  = 18,
    parameter int CMD_CAP = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic              cnt_sel,
    input  logic [7:0]        cnt_wdata,
    input  logic              dma_cmd,
    input  logic              xfer_start,
    input  logic              cmd_phase,
    input  logic [PLEN_W-1:0] phase_len,
    input  logic              byte_stb,
    input  logic              int_ack,
    output logic [CNT_W-1:0]  live_count,
    output logic [CNT_W:0]    remain,
    output logic              done,
    output logic              tc,
    output logic              svc,
    output logic              irq
);
    localparam int REM_W = CNT_W + 1;

    logic [CNT_W-1:0] shadow;
    logic [REM_W-1:0] eff_len;
    logic             complete;
    xfer_state_t      state;

    dmactr_shadow #(.CNT_W(CNT_W), .SEL_W(1)) u_shadow (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_sel(cnt_sel),
        .cnt_wdata(cnt_wdata), .dma_cmd(dma_cmd), .complete(complete),
        .shadow(shadow), .live(live_count)
    );

    dmactr_len #(.CNT_W(CNT_W), .PLEN_W(PLEN_W), .CMD_CAP(CMD_CAP)) u_len (
        .live(live_count), .cmd_phase(cmd_phase), .phase_len(phase_len),
        .eff_len(eff_len)
    );

    dmactr_fsm #(.REM_W(REM_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .byte_stb(byte_stb),
        .eff_len(eff_len), .remain(remain), .state(state),
        .complete(complete), .done(done)
    );

    // Completion wins over a clear that arrives in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc  <= 1'b0;
            svc <= 1'b0;
            irq <= 1'b0;
        end else begin
            if (complete)
                tc <= 1'b1;
            else if (cnt_wr || xfer_start)
                tc <= 1'b0;

            if (complete) begin
                svc <= 1'b1;
                irq <= 1'b1;
            end else if (int_ack) begin
                svc <= 1'b0;
                irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dmactr_chk.sv
module dmactr_chk
    import dmactr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CMD_CAP = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic             dma_cmd,
    input logic             xfer_start,
    input logic             cmd_phase,
    input logic             byte_stb,
    input logic             int_ack,
    input logic             complete,
    input xfer_state_t      state,
    input logic [CNT_W-1:0] shadow,
    input logic [CNT_W-1:0] live_count,
    input logic [CNT_W:0]   eff_len,
    input logic [CNT_W:0]   remain,
    input logic             done,
    input logic             tc,
    input logic             irq
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> remain == '0 && !tc && !irq); // R1
    AST_WR_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr && !complete |=> !tc); // R2
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cmd && !complete |=> live_count == $past(shadow)); // R3
    AST_CMD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_phase |-> eff_len <= (CNT_W+1)'(CMD_CAP)); // R5
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> remain == $past(eff_len)); // R6
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN && byte_stb && !xfer_start |=> remain == $past(remain) - 1'b1); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !xfer_start |=> !done); // R8
    AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tc && irq && live_count == '0); // R8
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        remain == '0 && !xfer_start |=> remain == '0); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack && !complete |=> !irq); // R10
endmodule

bind dmactr_top dmactr_chk #(.CNT_W(CNT_W), .CMD_CAP(CMD_CAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .dma_cmd(dma_cmd),
    .xfer_start(xfer_start), .cmd_phase(cmd_phase), .byte_stb(byte_stb),
    .int_ack(int_ack), .complete(complete), .state(state), .shadow(shadow),
    .live_count(live_count), .eff_len(eff_len), .remain(remain),
    .done(done), .tc(tc), .irq(irq)
);

// File: tb/dmactr_top_test.sv
`timescale 1ns/100ps
module dmactr_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr = 1'b0, cnt_sel = 1'b0, dma_cmd = 1'b0, xfer_start = 1'b0;
    logic        cmd_phase = 1'b0, byte_stb = 1'b0, int_ack = 1'b0;
    logic [7:0]  cnt_wdata = 8'h00;
    logic [17:0] phase_len = '0;
    logic [15:0] live_count;
    logic [16:0] remain;
    logic        done, tc, svc, irq;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dmactr_top uut (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_sel(cnt_sel),
        .cnt_wdata(cnt_wdata), .dma_cmd(dma_cmd), .xfer_start(xfer_start),
        .cmd_phase(cmd_phase), .phase_len(phase_len), .byte_stb(byte_stb),
        .int_ack(int_ack), .live_count(live_count), .remain(remain),
        .done(done), .tc(tc), .svc(svc), .irq(irq)
    );

    // Columns: count, command phase, signed phase length, expected length.
    localparam int NV = 8;
    localparam int V_CNT [NV] = '{100, 100, 20, 0, 0, 10, 4660, 5};
    localparam int V_CMD [NV] = '{0, 0, 0, 0, 1, 1, 0, 0};
    localparam int V_PL  [NV] = '{40, -40, 300, 70000, 0, 9999, -5000, 0};
    localparam int V_EXP [NV] = '{40, 40, 20, 65536, 32, 10, 4660, 0};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_byte(input logic sel, input logic [7:0] d);
        cnt_wr = 1'b1; cnt_sel = sel; cnt_wdata = d;
        tick();
        cnt_wr = 1'b0;
    endtask

    task automatic pulse_cmd();
        dma_cmd = 1'b1; tick(); dma_cmd = 1'b0;
    endtask

    task automatic pulse_start();
        xfer_start = 1'b1; tick(); xfer_start = 1'b0;
    endtask

    task automatic pulse_byte();
        byte_stb = 1'b1; tick(); byte_stb = 1'b0;
    endtask

    task automatic pulse_ack();
        int_ack = 1'b1; tick(); int_ack = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        // R1: state after reset
        check("R1 live", int'(live_count), 0);
        check("R1 remain", int'(remain), 0);
        check("R1 flags", int'({done, tc, svc, irq}), 0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            write_byte(1'b0, 8'(V_CNT[i]));
            write_byte(1'b1, 8'(V_CNT[i] >> 8));
            pulse_cmd();
            check("R3 reload", int'(live_count), V_CNT[i]);
            cmd_phase = V_CMD[i][0];
            phase_len = 18'(V_PL[i]);
            pulse_start();
            // R4 R5 R6 effective length, R11 immediate completion
            check("R4/R5/R6 length", int'(remain), V_EXP[i]);
            check("R11 done", int'(done), (V_EXP[i] == 0) ? 1 : 0);
            pulse_ack();
        end

        // Directed: count of 3 against a phase length of 100.
        cmd_phase = 1'b0; phase_len = 18'd100;
        write_byte(1'b0, 8'd3);
        write_byte(1'b1, 8'd0);
        pulse_cmd();
        pulse_start();
        check("R6 tc cleared", int'(tc), 0);
        check("R6 remain", int'(remain), 3);
        pulse_byte();
        check("R7 first", int'(remain), 2);
        pulse_byte();
        check("R7 second", int'(remain), 1);
        tick();
        check("R7 hold", int'(remain), 1);
        pulse_byte();
        check("R8 remain", int'(remain), 0);
        check("R8 done", int'(done), 1);
        check("R8 tc/svc/irq", int'({tc, svc, irq}), 7);
        check("R8 live zeroed", int'(live_count), 0);
        tick();
        check("R8 single pulse", int'(done), 0);
        pulse_byte();
        check("R9 remain", int'(remain), 0);
        check("R9 no done", int'(done), 0);
        pulse_ack();
        check("R10 irq/svc", int'({svc, irq}), 0);
        check("R10 tc kept", int'(tc), 1);
        write_byte(1'b0, 8'd7);
        check("R2 tc cleared", int'(tc), 0);
        check("R2 live unchanged", int'(live_count), 0);
        pulse_cmd();
        check("R3 directed", int'(live_count), 7);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule